// File: doc/BRIEF.md
# Software-Refilled Translation Lookaside Buffer

This block caches virtual-to-physical page translations for a 32-bit virtual address space with 4 KB pages. On each access it takes the upper 20 address bits as the virtual page number and compares it against every stored entry in parallel. In the same cycle it returns a 26-bit physical address, built from the matching entry's 14-bit physical page number and the untranslated 12-bit offset, together with a hit, miss or protection-fault indication.

The block has no knowledge of any page table layout. When a lookup misses, or when it is refused for lack of rights, the block raises an output and captures the faulting virtual address. System software then resolves the fault and installs a new entry through the fill port. The block chooses the slot to use: the lowest free slot if one exists, and otherwise a victim picked by a second-chance sweep over per-entry reference bits. During a fill it reports the displaced entry and its dirty bit, so that software can write a modified page back. An invalidate-all input empties the buffer in one cycle when the process changes.

Top module: `tlb_sw_refill`

## Requirements
- R1: Address split and translation. When `req_valid_i` is high and a valid entry's page number equals `req_vaddr_i[31:12]`, and that entry's rights allow the access, `hit_o` is high in the same cycle. In that case `paddr_o` equals {entry physical page number, `req_vaddr_i[11:0]`}.
- R2: Miss trap. A request whose page number matches no valid entry drives `miss_trap_o` high in the same cycle. `fault_vaddr_o` takes the full request address at the next clock edge after a miss or a protection fault, and it holds its value otherwise. With no request, `hit_o`, `miss_trap_o` and `prot_fault_o` are all low.
- R3: Rights check. Rights bit 0 means readable and rights bit 1 means writable. A load that matches an entry without bit 0 set, or a store that matches an entry without bit 1 set, raises `prot_fault_o` instead of `hit_o`. Such an access changes neither the reference bit nor the dirty bit of that entry.
- R4: A permitted hit sets the entry's reference bit at the clock edge.
- R5: A permitted store hit sets the entry's dirty bit at the clock edge. A newly installed entry starts clean and unreferenced. `evict_dirty_o` reports the dirty bit of the entry about to be displaced.
- R6: A fill (`fill_valid_i` high) uses the lowest-numbered invalid slot while any slot is free. In that case nothing is evicted and the rotating pointer does not move.
- R7: When every slot is valid, the victim is the first slot, scanning upward from the rotating pointer with wrap-around, whose reference bit is clear. The pointer then moves to the slot after the victim, modulo the entry count.
- R8: When every slot is valid and every reference bit is set, the fill clears all reference bits and replaces the slot at the pointer.
- R9: During a fill that displaces a valid entry, `evict_valid_o` is high in that same cycle, and `evict_vpn_o` and `evict_dirty_o` describe the displaced entry. `evict_valid_o` is low in every other cycle.
- R10: `flush_i` invalidates every entry at the next edge. A fill presented in the same cycle is discarded. Every request after the flush misses until new fills arrive.
- R11: After reset every entry is invalid, the pointer is 0 and `fault_vaddr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request this cycle |
| req_vaddr_i | input | 32 | Virtual address of the access |
| req_store_i | input | 1 | Access is a store (1) or a load/fetch (0) |
| hit_o | output | 1 | Translation found and permitted |
| paddr_o | output | 26 | Physical address, meaningful when `hit_o` is high |
| miss_trap_o | output | 1 | No valid entry matched |
| prot_fault_o | output | 1 | Entry matched but the rights refuse the access |
| fault_vaddr_o | output | 32 | Address of the last miss or protection fault |
| fill_valid_i | input | 1 | Install a new entry |
| fill_vpn_i | input | 20 | Virtual page number of the new entry |
| fill_ppn_i | input | 14 | Physical page number of the new entry |
| fill_rights_i | input | 2 | Rights of the new entry (bit 0 read, bit 1 write) |
| evict_valid_o | output | 1 | The current fill displaces a valid entry |
| evict_vpn_o | output | 20 | Page number of the displaced entry |
| evict_dirty_o | output | 1 | The displaced entry was written |
| flush_i | input | 1 | Invalidate all entries |

## Verification
The bench builds the block with `ENTRIES = 4` instead of 16, so that four fills fill the buffer. Every replacement path then comes within a few cycles: the full second-chance sweep, a wrap of the rotating pointer past the last slot, and a skip over referenced entries. Fresh page numbers in the random phase keep the replacement logic under constant pressure, and occasional flushes cover the case where a fill arrives in the same cycle as an invalidate-all.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = 14;
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int RT_W  = 2;
  localparam int RT_RD = 0;
  localparam int RT_WR = 1;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][VPN_W-1:0] vpn_i,
  input  logic [VPN_W-1:0]        key_i,
  output logic [N-1:0]            match_o,
  output logic [IDX_W-1:0]        idx_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (vpn_i[g] == key_i);
  end

  // lowest matching slot; software keeps page numbers unique
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_o[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid_i,
  input  logic [N-1:0]     ref_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [IDX_W-1:0] victim_o,
  output logic             full_o,
  output logic             sweep_o
);
  logic found;

  assign full_o = &valid_i;

  always_comb begin
    victim_o = ptr_i;
    found    = 1'b0;
    sweep_o  = 1'b0;
    if (!full_o) begin
      for (int i = N - 1; i >= 0; i--) begin
        if (!valid_i[i]) victim_o = IDX_W'(i);
      end
    end else begin
      // second chance: first unreferenced slot from the pointer, wrapping
      for (int k = 0; k < N; k++) begin
        if (!found && !ref_i[(int'(ptr_i) + k) % N]) begin
          victim_o = IDX_W'((int'(ptr_i) + k) % N);
          found    = 1'b1;
        end
      end
      sweep_o = !found;
    end
  end
endmodule

// File: rtl/tlb_sw_refill.sv
module tlb_sw_refill
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_store_i,
  output logic             hit_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic             miss_trap_o,
  output logic             prot_fault_o,
  output logic [VA_W-1:0]  fault_vaddr_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic [RT_W-1:0]  fill_rights_i,
  output logic             evict_valid_o,
  output logic [VPN_W-1:0] evict_vpn_o,
  output logic             evict_dirty_o,
  input  logic             flush_i
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  logic [ENTRIES-1:0][RT_W-1:0]  rights_q;
  logic [ENTRIES-1:0]            valid_q, ref_q, dirty_q;
  logic [ENTRIES-1:0]            valid_n, ref_n, dirty_n;
  logic [IDX_W-1:0]              ptr_q;

  logic [ENTRIES-1:0] match_vec;
  logic [IDX_W-1:0]   hit_idx, victim;
  logic               match_any, allowed, full, sweep, fill_go;
  logic [RT_W-1:0]    sel_rights;

  tlb_cam #(.N(ENTRIES), .IDX_W(IDX_W)) u_cam (
    .valid_i (valid_q),
    .vpn_i   (vpn_q),
    .key_i   (req_vaddr_i[VA_W-1:OFF_W]),
    .match_o (match_vec),
    .idx_o   (hit_idx)
  );

  tlb_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .valid_i  (valid_q),
    .ref_i    (ref_q),
    .ptr_i    (ptr_q),
    .victim_o (victim),
    .full_o   (full),
    .sweep_o  (sweep)
  );

  assign match_any  = |match_vec;
  assign sel_rights = rights_q[hit_idx];
  assign allowed    = req_store_i ? sel_rights[RT_WR] : sel_rights[RT_RD];

  assign hit_o        = req_valid_i && match_any && allowed;
  assign prot_fault_o = req_valid_i && match_any && !allowed;
  assign miss_trap_o  = req_valid_i && !match_any;
  assign paddr_o      = {ppn_q[hit_idx], req_vaddr_i[OFF_W-1:0]};

  assign fill_go       = fill_valid_i && !flush_i;
  assign evict_valid_o = fill_go && valid_q[victim];
  assign evict_vpn_o   = vpn_q[victim];
  assign evict_dirty_o = dirty_q[victim];

  always_comb begin
    valid_n = valid_q;
    ref_n   = ref_q;
    dirty_n = dirty_q;
    if (flush_i) begin
      valid_n = '0;
      ref_n   = '0;
      dirty_n = '0;
    end else begin
      if (fill_go && sweep) ref_n = '0;
      if (hit_o) begin
        ref_n[hit_idx] = 1'b1;
        if (req_store_i) dirty_n[hit_idx] = 1'b1;
      end
      if (fill_go) begin
        valid_n[victim] = 1'b1;
        ref_n[victim]   = 1'b0;
        dirty_n[victim] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q       <= '0;
      ref_q         <= '0;
      dirty_q       <= '0;
      vpn_q         <= '0;
      ppn_q         <= '0;
      rights_q      <= '0;
      ptr_q         <= '0;
      fault_vaddr_o <= '0;
    end else begin
      valid_q <= valid_n;
      ref_q   <= ref_n;
      dirty_q <= dirty_n;
      if (fill_go) begin
        vpn_q[victim]    <= fill_vpn_i;
        ppn_q[victim]    <= fill_ppn_i;
        rights_q[victim] <= fill_rights_i;
        if (full) ptr_q <= (int'(victim) == ENTRIES - 1) ? '0 : victim + 1'b1;
      end
      if (miss_trap_o || prot_fault_o) fault_vaddr_o <= req_vaddr_i;
    end
  end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk
  import tlb_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic [VA_W-1:0]  req_vaddr_i,
  input logic             hit_o,
  input logic             miss_trap_o,
  input logic             prot_fault_o,
  input logic [VA_W-1:0]  fault_vaddr_o,
  input logic             fill_valid_i,
  input logic             evict_valid_o,
  input logic             flush_i
);
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> $countones({hit_o, miss_trap_o, prot_fault_o}) == 1); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !(hit_o || miss_trap_o || prot_fault_o)); // R2

  AST_FAULT_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_trap_o || prot_fault_o) |=> fault_vaddr_o == $past(req_vaddr_i)); // R2

  AST_FAULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(miss_trap_o || prot_fault_o) |=> $stable(fault_vaddr_o)); // R2

  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(flush_i) && req_valid_i) |-> miss_trap_o); // R10

  AST_EVICT_ON_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_valid_o |-> (fill_valid_i && !flush_i)); // R9
endmodule

bind tlb_sw_refill tlb_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_vaddr_i   (req_vaddr_i),
  .hit_o         (hit_o),
  .miss_trap_o   (miss_trap_o),
  .prot_fault_o  (prot_fault_o),
  .fault_vaddr_o (fault_vaddr_o),
  .fill_valid_i  (fill_valid_i),
  .evict_valid_o (evict_valid_o),
  .flush_i       (flush_i)
);

// File: tb/sim_tlb_sw_refill.sv
module sim_tlb_sw_refill;
  localparam int N = 4;
  localparam time HALF = 2.5ns;

  logic        clk = 0, rst_n = 0;
  logic        req_v = 0, req_st = 0, fill_v = 0, flush = 0;
  logic [31:0] vaddr = 0;
  logic [19:0] f_vpn = 0;
  logic [13:0] f_ppn = 0;
  logic [1:0]  f_rt = 0;
  logic        hit, miss, prot, ev_v, ev_d;
  logic [25:0] paddr;
  logic [31:0] fva;
  logic [19:0] ev_vpn;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur = "R11";

  // reference model
  logic [19:0] m_vpn [N];
  logic [13:0] m_ppn [N];
  logic [1:0]  m_rt  [N];
  bit          m_val [N], m_ref [N], m_dty [N];
  int          m_ptr = 0;
  logic [31:0] m_fva = 0;
  // expectations of the current cycle
  bit e_hit, e_miss, e_prot, e_full, e_sweep, e_ev;
  int e_idx, e_vic;

  tlb_sw_refill #(.ENTRIES(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_v), .req_vaddr_i(vaddr), .req_store_i(req_st),
    .hit_o(hit), .paddr_o(paddr), .miss_trap_o(miss), .prot_fault_o(prot),
    .fault_vaddr_o(fva),
    .fill_valid_i(fill_v), .fill_vpn_i(f_vpn), .fill_ppn_i(f_ppn), .fill_rights_i(f_rt),
    .evict_valid_o(ev_v), .evict_vpn_o(ev_vpn), .evict_dirty_o(ev_d),
    .flush_i(flush)
  );

  always #HALF clk = ~clk;

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] %s act=%h exp=%h", rq, cur, what, act, exp);
    end
  endtask

  task automatic compute();
    bit found;
    e_idx = -1;
    for (int i = N - 1; i >= 0; i--)
      if (m_val[i] && m_vpn[i] == vaddr[31:12]) e_idx = i;
    e_hit = 0; e_miss = 0; e_prot = 0;
    if (req_v) begin
      if (e_idx < 0) e_miss = 1;
      else if (m_rt[e_idx][req_st ? 1 : 0]) e_hit = 1;
      else e_prot = 1;
    end
    e_full = 1;
    for (int i = 0; i < N; i++) if (!m_val[i]) e_full = 0;
    e_sweep = 0; e_vic = m_ptr;
    if (!e_full) begin
      for (int i = N - 1; i >= 0; i--) if (!m_val[i]) e_vic = i;
    end else begin
      found = 0;
      for (int k = 0; k < N; k++)
        if (!found && !m_ref[(m_ptr + k) % N]) begin e_vic = (m_ptr + k) % N; found = 1; end
      e_sweep = !found;
    end
    e_ev = fill_v && !flush && m_val[e_vic];
  endtask

  task automatic drive(bit rv, logic [31:0] va, bit st, bit fv, logic [19:0] fvpn,
                       logic [13:0] fppn, logic [1:0] frt, bit fl);
    @(negedge clk);
    req_v = rv; vaddr = va; req_st = st; fill_v = fv; f_vpn = fvpn; f_ppn = fppn;
    f_rt = frt; flush = fl;
    #1;
    compute();
    chk("R1", "hit", 32'(hit), 32'(e_hit));
    chk("R2", "miss", 32'(miss), 32'(e_miss));
    chk("R3", "prot", 32'(prot), 32'(e_prot));
    chk("R2", "fault_vaddr", fva, m_fva);
    chk("R9", "evict_valid", 32'(ev_v), 32'(e_ev));
    if (e_hit) chk("R1", "paddr", 32'(paddr), 32'({m_ppn[e_idx], vaddr[11:0]}));
    if (e_ev) begin
      chk("R7", "evict_vpn", 32'(ev_vpn), 32'(m_vpn[e_vic]));
      chk("R5", "evict_dirty", 32'(ev_d), 32'(m_dty[e_vic]));
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (flush) begin
      for (int i = 0; i < N; i++) begin m_val[i] = 0; m_ref[i] = 0; m_dty[i] = 0; end
    end else begin
      if (fill_v && e_sweep) for (int i = 0; i < N; i++) m_ref[i] = 0;
      if (e_hit) begin m_ref[e_idx] = 1; if (req_st) m_dty[e_idx] = 1; end
      if (fill_v) begin
        m_val[e_vic] = 1; m_ref[e_vic] = 0; m_dty[e_vic] = 0;
        m_vpn[e_vic] = f_vpn; m_ppn[e_vic] = f_ppn; m_rt[e_vic] = f_rt;
        if (e_full) m_ptr = (e_vic + 1) % N;
      end
    end
    if (e_miss || e_prot) m_fva = vaddr;
  endtask

  task automatic look(logic [19:0] vpn, logic [11:0] off, bit st);
    drive(1, {vpn, off}, st, 0, 0, 0, 0, 0); step();
  endtask

  task automatic fill(logic [19:0] vpn, logic [13:0] ppn, logic [1:0] rt);
    drive(0, 0, 0, 1, vpn, ppn, rt, 0); step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(HALF * 2 * 150000);
    errors++;
    $display("FAIL watchdog [%s] act=running exp=finished", cur);
    finish_run();
  end

  initial begin
    logic [31:0] lf;
    bit dup;
    for (int i = 0; i < N; i++) begin
      m_val[i] = 0; m_ref[i] = 0; m_dty[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_rt[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R11: empty after reset, fault address cleared
    cur = "R11";
    drive(1, 32'h0001_2345, 0, 0, 0, 0, 0, 0);
    chk("R11", "reset miss", 32'(miss), 32'd1);
    chk("R11", "reset fva", fva, 32'd0);
    step();

    // R6: fills go to lowest free slots
    cur = "R6";
    fill(20'h10, 14'h100, 2'b11);
    fill(20'h11, 14'h101, 2'b01);
    fill(20'h12, 14'h102, 2'b10);
    fill(20'h13, 14'h103, 2'b11);

    // R1 translation, R3 rights refusals
    cur = "R1";
    drive(1, {20'h13, 12'hABC}, 0, 0, 0, 0, 0, 0);
    chk("R1", "paddr e3", 32'(paddr), 32'({14'h103, 12'hABC}));
    step();
    cur = "R3";
    drive(1, {20'h11, 12'h004}, 1, 0, 0, 0, 0, 0);
    chk("R3", "store to read-only", 32'(prot), 32'd1);
    step();
    look(20'h12, 12'h008, 0);

    // R4/R5: reference every entry, dirty 0x10 and 0x12
    cur = "R4";
    look(20'h10, 12'h010, 1);
    look(20'h11, 12'h014, 0);
    look(20'h12, 12'h018, 1);
    look(20'h13, 12'h01C, 0);

    // R8: all referenced -> sweep, victim at pointer 0
    cur = "R8";
    drive(0, 0, 0, 1, 20'h14, 14'h104, 2'b11, 0);
    chk("R8", "sweep victim", 32'(ev_vpn), 32'h10);
    chk("R5", "victim dirty", 32'(ev_d), 32'd1);
    step();

    // R3: refused store on 0x11 must not reference it
    cur = "R3";
    look(20'h11, 12'h020, 1);
    look(20'h13, 12'h024, 0);
    drive(0, 0, 0, 1, 20'h15, 14'h105, 2'b11, 0);
    chk("R3", "refused access left ref clear", 32'(ev_vpn), 32'h11);
    step();

    // R7: skip referenced slots with wrap
    cur = "R7";
    look(20'h12, 12'h028, 1);
    drive(0, 0, 0, 1, 20'h16, 14'h106, 2'b01, 0);
    chk("R7", "wrap victim", 32'(ev_vpn), 32'h14);
    chk("R5", "clean victim", 32'(ev_d), 32'd0);
    step();

    // R10: flush wins over a same-cycle fill
    cur = "R10";
    drive(0, 0, 0, 1, 20'h20, 14'h120, 2'b11, 1); step();
    drive(1, {20'h20, 12'h0}, 0, 0, 0, 0, 0, 0);
    chk("R10", "discarded fill", 32'(miss), 32'd1);
    step();
    look(20'h13, 12'h0, 0);
    cur = "R6";
    drive(0, 0, 0, 1, 20'h21, 14'h121, 2'b11, 0);
    chk("R6", "no evict while free", 32'(ev_v), 32'd0);
    step();
    look(20'h21, 12'h0FF, 0);

    // randomized mix against the model
    cur = "R7";
    lf = 32'h1234_5678;
    for (int n = 0; n < 2000; n++) begin
      lf = lf * 32'd1103515245 + 32'd12345;
      dup = 0;
      for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == 20'(32'h30 + lf[30:28])) dup = 1;
      drive(lf[16], {20'(32'h30 + lf[26:24]), lf[11:0]}, lf[17],
            !dup && (lf[22:20] < 3), 20'(32'h30 + lf[30:28]), lf[13:0], lf[19:18],
            lf[31:27] == 0);
      step();
    end

    finish_run();
  end
endmodule